// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block produces the vertical timing for one display pipe whose frame length may vary. It counts display lines, one per pulse of a horizontal line tick. From that count it drives the current line number, a vblank indicator, a one-clock frame start pulse and a one-clock strobe that tells the double-buffered timing registers elsewhere in the pipe when to take their new values.

In fixed mode the frame always has the same programmed total, and the register strobe fires when the count reaches the vblank start line. In variable mode the frame ends between a minimum and a maximum total. Software requests an early end by writing a push. The block does not end vblank before an earliest-exit line, which follows from the flip line or the minimum total. It does not wait past a latest line, which follows from the maximum total. Once the exit starts, the frame still runs for a guardband's worth of lines before the count wraps. A change to the enable bit takes effect only at a frame boundary, and a live status bit shows the mode actually in force.

Top module: `vrr_vtiming`

## Requirements
- R1: After reset the line number is 0. The frame start, register strobe and live status outputs are 0. The push word reads 0, the fixed total register reads 20 and the vblank start register reads 15.
- R2: In fixed mode the line number rises by one on each line tick. On the tick that ends line F it returns to 0, where F is the fixed-total register (address 5, line count minus one), so a frame lasts F+1 ticks. The line number never changes without a tick.
- R3: In fixed mode the register strobe is high for exactly one clock, on the edge where the line number becomes the vblank start line (address 6). vblank is high while the line number is at or above that line.
- R4: frame_start_o is high for exactly one clock, on the edge where the line number wraps to 0.
- R5: In variable mode with no push, the exit starts at line (MAX+1−G) and the frame lasts MAX+1 lines. MAX is the maximum-total register (address 2, count minus one) and G is the exit length.
- R6: A push written before the earliest-exit line is held pending. While pending it reads back as 1 in bit 1 of the push word (address 4), and it clears itself when the exit consumes it. With flip-line use enabled (control bit 2), the exit then starts at line FL+1−G and the frame lasts FL+1 lines, where FL is the flip-line register (address 3, count minus one).
- R7: A push written while the line number p lies between the earliest and latest exit lines starts the exit one clock after the write. The register strobe fires in that clock, and the frame lasts p+G lines.
- R8: With control bit 2 clear, the earliest-exit line is MIN+2−G, so a pending push gives a frame of MIN+2 lines. MIN is the minimum-total register (address 1).
- R9: Writing the enable (control bit 0) changes nothing until the next wrap to line 0. Then the live status (address 7, bit 0 and port vrr_live_o) takes the new value in the same clock as frame_start_o.
- R10: A push is accepted only when the write sets both bit 0 (push arm) and bit 1 (send) of the push word. A write with bit 0 clear leaves no pending push, and the frame still lasts MAX+1 lines.
- R11: The exit length G is the guardband field (control bits 15:8), except that a guardband of 0 is treated as 1.
- R12: Registers are written and read at 3-bit addresses. Address 0 holds the control word: bit 0 enable, bit 1 ignore-maximum flag (stored only), bit 2 flip-line use, bits 15:8 guardband. Address 4 holds the push word: bit 0 arm, bit 1 send. Address 7 is read-only status. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-clock pulse at the end of each display line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| line_o | output | 12 | Current line number |
| vblank_o | output | 1 | Vertical blanking active |
| frame_start_o | output | 1 | One-clock pulse when a frame begins |
| latch_o | output | 1 | One-clock strobe for double-buffered register update |
| vrr_live_o | output | 1 | Variable mode actually in force |

## Verification
A register write lands on the clock edge after wr_en is sampled. A pending push or a reached earliest or latest line starts the exit one edge later, and the register strobe appears in that same clock. A line tick moves the line number, the frame start pulse and the fixed-mode strobe on the edge that samples it, and the live status changes only on the wrapping edge. The bench keeps a reference model that advances on the same edges and compares every output on each falling edge, and compares the read port just before each rising edge. The directed frame-length checks count ticks between frame start pulses, so they do not depend on any single cycle.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_MIN   = 3'd1,
    A_MAX   = 3'd2,
    A_FLIP  = 3'd3,
    A_PUSH  = 3'd4,
    A_FIX   = 3'd5,
    A_VBS   = 3'd6,
    A_STAT  = 3'd7
  } reg_addr_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_IGN_BIT  = 1;
  localparam int CTL_FLIP_BIT = 2;
  localparam int CTL_GB_LSB   = 8;
  localparam int GB_W         = 8;
  localparam int PSH_ARM_BIT  = 0;
  localparam int PSH_SEND_BIT = 1;

  // exit sequence length: guardband, never below one line
  function automatic int exit_len_of(int gb);
    return (gb == 0) ? 1 : gb;
  endfunction

  function automatic int clamp_low(int v);
    return (v < 0) ? 0 : v;
  endfunction

  // first line on which a pending push may start the exit
  function automatic int earliest_line(int min_m1, int flip_m1, bit use_flip, int len);
    int base;
    base = use_flip ? (flip_m1 + 1) : (min_m1 + 2);
    return clamp_low(base - len);
  endfunction

  // line on which the exit is forced
  function automatic int latest_line(int max_m1, int len);
    return clamp_low(max_m1 + 1 - len);
  endfunction

endpackage

// File: rtl/vrr_regs.sv
module vrr_regs
  import vrr_pkg::*;
#(
  parameter int LW         = 12,
  parameter int DEF_FIX_M1 = 20,
  parameter int DEF_VBS    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              consume,
  input  logic              live,
  output logic              en,
  output logic              use_flip,
  output logic [GB_W-1:0]   gb,
  output logic [LW-1:0]     min_m1,
  output logic [LW-1:0]     max_m1,
  output logic [LW-1:0]     flip_m1,
  output logic [LW-1:0]     fix_m1,
  output logic [LW-1:0]     vbs,
  output logic              push_send
);

  localparam int PAD = DATA_W - LW;

  logic ign_max;
  logic push_arm;
  logic send_d;

  function automatic logic [DATA_W-1:0] widen(logic [LW-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  // consumption first, then a write may set or clear the send bit
  always_comb begin
    send_d = consume ? 1'b0 : push_send;
    if (wr_en && wr_addr == A_PUSH)
      send_d = wr_data[PSH_ARM_BIT] & (wr_data[PSH_SEND_BIT] | send_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en        <= 1'b0;
      ign_max   <= 1'b0;
      use_flip  <= 1'b0;
      gb        <= '0;
      min_m1    <= '0;
      max_m1    <= '0;
      flip_m1   <= '0;
      fix_m1    <= LW'(DEF_FIX_M1);
      vbs       <= LW'(DEF_VBS);
      push_arm  <= 1'b0;
      push_send <= 1'b0;
    end else begin
      push_send <= send_d;
      if (wr_en) begin
        unique case (wr_addr)
          A_CTRL: begin
            en       <= wr_data[CTL_EN_BIT];
            ign_max  <= wr_data[CTL_IGN_BIT];
            use_flip <= wr_data[CTL_FLIP_BIT];
            gb       <= wr_data[CTL_GB_LSB +: GB_W];
          end
          A_MIN:  min_m1   <= wr_data[LW-1:0];
          A_MAX:  max_m1   <= wr_data[LW-1:0];
          A_FLIP: flip_m1  <= wr_data[LW-1:0];
          A_PUSH: push_arm <= wr_data[PSH_ARM_BIT];
          A_FIX:  fix_m1   <= wr_data[LW-1:0];
          A_VBS:  vbs      <= wr_data[LW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL: begin
        rd_data[CTL_EN_BIT]             = en;
        rd_data[CTL_IGN_BIT]            = ign_max;
        rd_data[CTL_FLIP_BIT]           = use_flip;
        rd_data[CTL_GB_LSB +: GB_W]     = gb;
      end
      A_MIN:  rd_data = widen(min_m1);
      A_MAX:  rd_data = widen(max_m1);
      A_FLIP: rd_data = widen(flip_m1);
      A_PUSH: begin
        rd_data[PSH_ARM_BIT]  = push_arm;
        rd_data[PSH_SEND_BIT] = push_send;
      end
      A_FIX:  rd_data = widen(fix_m1);
      A_VBS:  rd_data = widen(vbs);
      A_STAT: rd_data[0] = live;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/vrr_window.sv
module vrr_window
  import vrr_pkg::*;
#(
  parameter int LW = 12
) (
  input  logic [GB_W-1:0] gb,
  input  logic            use_flip,
  input  logic [LW-1:0]   min_m1,
  input  logic [LW-1:0]   max_m1,
  input  logic [LW-1:0]   flip_m1,
  output logic [LW-1:0]   exit_len,
  output logic [LW-1:0]   early_line,
  output logic [LW-1:0]   late_line
);

  int len_i;

  always_comb begin
    len_i      = exit_len_of(int'(gb));
    exit_len   = LW'(len_i);
    early_line = LW'(earliest_line(int'(min_m1), int'(flip_m1), use_flip, len_i));
    late_line  = LW'(latest_line(int'(max_m1), len_i));
  end

endmodule

// File: rtl/vrr_line_ctr.sv
module vrr_line_ctr #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en_req,
  input  logic [LW-1:0] fix_m1,
  input  logic [LW-1:0] vbs,
  input  logic [LW-1:0] exit_len,
  input  logic [LW-1:0] early_line,
  input  logic [LW-1:0] late_line,
  input  logic          push_send,
  output logic [LW-1:0] line,
  output logic          in_exit,
  output logic          frame_start,
  output logic          latch,
  output logic          live,
  output logic          exit_go
);

  logic [LW-1:0] last_q, last_d, line_inc;
  logic          inx_d, wrap;

  always_comb begin
    exit_go  = live && !in_exit &&
               ((push_send && line >= early_line) || line >= late_line);
    last_d   = exit_go ? (line + exit_len - LW'(1)) : last_q;
    inx_d    = in_exit | exit_go;
    wrap     = live ? (inx_d && line >= last_d) : (line >= fix_m1);
    line_inc = line + LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line        <= '0;
      in_exit     <= 1'b0;
      last_q      <= '0;
      frame_start <= 1'b0;
      latch       <= 1'b0;
      live        <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      latch       <= exit_go;
      in_exit     <= inx_d;
      last_q      <= last_d;
      if (tick) begin
        if (wrap) begin
          line        <= '0;
          frame_start <= 1'b1;
          in_exit     <= 1'b0;
          live        <= en_req;
        end else begin
          line <= line_inc;
          if (!live && line_inc == vbs) latch <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vrr_vtiming.sv
module vrr_vtiming
  import vrr_pkg::*;
#(
  parameter int LW         = 12,
  parameter int DEF_FIX_M1 = 20,
  parameter int DEF_VBS    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     line_o,
  output logic              vblank_o,
  output logic              frame_start_o,
  output logic              latch_o,
  output logic              vrr_live_o
);

  logic            en, use_flip, push_send, exit_go, in_exit;
  logic [GB_W-1:0] gb;
  logic [LW-1:0]   min_m1, max_m1, flip_m1, fix_m1, vbs;
  logic [LW-1:0]   exit_len, early_line, late_line;

  vrr_regs #(.LW(LW), .DEF_FIX_M1(DEF_FIX_M1), .DEF_VBS(DEF_VBS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .consume(exit_go), .live(vrr_live_o),
    .en(en), .use_flip(use_flip), .gb(gb), .min_m1(min_m1), .max_m1(max_m1),
    .flip_m1(flip_m1), .fix_m1(fix_m1), .vbs(vbs), .push_send(push_send)
  );

  vrr_window #(.LW(LW)) u_win (
    .gb(gb), .use_flip(use_flip), .min_m1(min_m1), .max_m1(max_m1),
    .flip_m1(flip_m1), .exit_len(exit_len), .early_line(early_line),
    .late_line(late_line)
  );

  vrr_line_ctr #(.LW(LW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .en_req(en), .fix_m1(fix_m1),
    .vbs(vbs), .exit_len(exit_len), .early_line(early_line), .late_line(late_line),
    .push_send(push_send), .line(line_o), .in_exit(in_exit),
    .frame_start(frame_start_o), .latch(latch_o), .live(vrr_live_o),
    .exit_go(exit_go)
  );

  assign vblank_o = (line_o >= vbs);

endmodule

// File: rtl/vrr_vtiming_chk.sv
module vrr_vtiming_chk
  import vrr_pkg::*;
#(
  parameter int LW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LW-1:0]     line_o,
  input logic              frame_start_o,
  input logic              latch_o,
  input logic              vrr_live_o,
  input logic              push_send,
  input logic              in_exit
);

  // R4
  fs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> line_o == '0);

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(line_o));

  // R9
  live_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vrr_live_o) |-> frame_start_o);

  // R6
  send_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(push_send) && !$past(wr_en && wr_addr == A_PUSH)) |-> latch_o);

  // R7
  vrr_latch_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_o && vrr_live_o && !frame_start_o) |-> in_exit);

endmodule

bind vrr_vtiming vrr_vtiming_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .line_o(line_o), .frame_start_o(frame_start_o),
  .latch_o(latch_o), .vrr_live_o(vrr_live_o), .push_send(push_send),
  .in_exit(in_exit)
);

// File: tb/sim_vrr_vtiming.sv
module sim_vrr_vtiming;

  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd4;
  logic [15:0] rd_data;
  logic [LW-1:0] line_o;
  logic        vblank_o, frame_start_o, latch_o, vrr_live_o;

  vrr_vtiming u0 (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .line_o(line_o), .vblank_o(vblank_o), .frame_start_o(frame_start_o),
    .latch_o(latch_o), .vrr_live_o(vrr_live_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int m_line, m_last, m_fix = 20, m_vbs = 15, m_min, m_max, m_flip, m_gb;
  bit m_live, m_inx, m_en, m_ign, m_fe, m_arm, m_send, m_fs, m_lat, m_tick_last;

  function automatic int m_read(int a);
    case (a)
      0: return m_en | (m_ign << 1) | (m_fe << 2) | (m_gb << 8);
      1: return m_min;
      2: return m_max;
      3: return m_flip;
      4: return m_arm | (m_send << 1);
      5: return m_fix;
      6: return m_vbs;
      default: return m_live;
    endcase
  endfunction

  always @(posedge clk) begin
    int len, early, late, base;
    bit go, nin, wrap;
    int nlast;
    if (rst_n) chk("R12", rd_data, m_read(rd_addr), "read data");
    m_tick_last = line_tick;
    if (!rst_n) begin
      m_line = 0; m_last = 0; m_fix = 20; m_vbs = 15; m_min = 0; m_max = 0;
      m_flip = 0; m_gb = 0; m_live = 0; m_inx = 0; m_en = 0; m_ign = 0;
      m_fe = 0; m_arm = 0; m_send = 0; m_fs = 0; m_lat = 0;
    end else begin
      len   = (m_gb == 0) ? 1 : m_gb;
      base  = m_fe ? m_flip + 1 : m_min + 2;
      early = (base - len < 0) ? 0 : base - len;
      late  = (m_max + 1 - len < 0) ? 0 : m_max + 1 - len;
      go    = m_live && !m_inx && ((m_send && m_line >= early) || m_line >= late);
      nin = m_inx; nlast = m_last; m_fs = 0; m_lat = 0;
      if (go) begin nin = 1; nlast = (m_line + len - 1) % (1 << LW); m_lat = 1; m_send = 0; end
      if (line_tick) begin
        wrap = m_live ? (nin && m_line >= nlast) : (m_line >= m_fix);
        if (wrap) begin
          m_line = 0; m_fs = 1; nin = 0; m_live = m_en;
        end else begin
          m_line = m_line + 1;
          if (!m_live && m_line == m_vbs) m_lat = 1;
        end
      end
      m_inx = nin; m_last = nlast;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin m_en = wr_data[0]; m_ign = wr_data[1]; m_fe = wr_data[2]; m_gb = wr_data[15:8]; end
          3'd1: m_min = wr_data[11:0];
          3'd2: m_max = wr_data[11:0];
          3'd3: m_flip = wr_data[11:0];
          3'd4: begin m_arm = wr_data[0]; m_send = wr_data[0] & (wr_data[1] | m_send); end
          3'd5: m_fix = wr_data[11:0];
          3'd6: m_vbs = wr_data[11:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  int tick_cnt = 0, last_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", line_o, m_line, "line number");
      chk("R3", vblank_o, (m_line >= m_vbs), "vblank");
      chk("R3", latch_o, m_lat, "register strobe");
      chk("R4", frame_start_o, m_fs, "frame start");
      chk("R9", vrr_live_o, m_live, "live status");
      if (m_tick_last) tick_cnt++;
      if (frame_start_o) begin last_len = tick_cnt; tick_cnt = 0; end
    end
  end

  // ---------------- tick generator and watchdog ----------------
  int phase = 0;
  always @(negedge clk) begin
    phase = (phase + 1) % 4;
    line_tick <= (phase == 3);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk("WDOG", 0, 1, "watchdog expired");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start_o);
    #1;
  endtask

  task automatic wait_line(int v);
    do @(negedge clk); while (line_o != v[LW-1:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", frame_start_o, 0, "frame start after reset");
    chk("R1", vrr_live_o, 0, "live after reset");
    chk("R1", rd_data, 0, "push word after reset");
    chk("R1", int'(line_o) <= 1, 1, "line after reset");

    // fixed mode: total 25, vblank from 18
    wr(5, 24); wr(6, 18);
    wait_fs(); wait_fs();
    chk("R2", last_len, 25, "fixed frame length");
    wait_line(17);
    chk("R3", vblank_o, 0, "vblank before start line");
    wait_line(18);
    chk("R3", latch_o, 1, "strobe at vblank start");
    chk("R3", vblank_o, 1, "vblank at start line");

    // variable mode: MIN 30, MAX 60, FL 32, G 4
    wr(1, 30); wr(2, 60); wr(3, 32); wr(4, 1);
    wr(0, 16'h0405);
    chk("R9", vrr_live_o, 0, "live before boundary");
    wait_fs();
    chk("R9", vrr_live_o, 1, "live at boundary");
    wait_fs();
    chk("R5", last_len, 61, "no-push frame length");

    // early push held pending
    wr(4, 3);
    chk("R6", rd_data[1], 1, "send pending readback");
    wait_fs();
    chk("R6", last_len, 33, "pending push frame length");
    chk("R6", rd_data[1], 0, "send cleared after exit");

    // push inside the window at line 40
    wait_fs();
    wait_line(40);
    wr(4, 3);
    @(negedge clk);
    chk("R7", latch_o, 1, "strobe one clock after push");
    wait_fs();
    chk("R7", last_len, 44, "in-window push frame length");

    // flip line use off
    wr(0, 16'h0401);
    wait_fs();
    wr(4, 3);
    wait_fs();
    chk("R8", last_len, 32, "frame length from minimum");

    // guardband zero treated as one
    wr(0, 16'h0005);
    wait_fs();
    wait_line(40);
    wr(4, 3);
    wait_fs();
    chk("R11", last_len, 41, "zero guardband exit length");

    // unarmed push ignored
    wait_fs();
    wr(4, 2);
    chk("R10", rd_data[1], 0, "unarmed send not pending");
    wait_fs();
    chk("R10", last_len, 61, "unarmed push frame length");

    // disable returns to fixed timing at the boundary
    wr(0, 0);
    chk("R9", vrr_live_o, 1, "live held until boundary");
    wait_fs();
    chk("R9", vrr_live_o, 0, "live cleared at boundary");
    wait_fs();
    chk("R2", last_len, 25, "fixed length after disable");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule